// File: doc/BRIEF.md
# Dual-Channel Bus-Master DMA Register File

This block is the byte-wide register bank in front of a two-channel disk controller's bus-master DMA engine. Software reaches it over a simple synchronous byte bus. Each channel has a 4-byte window, and the two windows sit 8 bytes apart. A window holds four registers:

- a command byte, whose start and direction bits drive the DMA engine;
- a view of one mode register that both channels share;
- a status byte that mixes an engine-driven flag, write-1-to-clear event bits and plain read/write bits;
- a timing byte that belongs to the channel.

The shared mode register records which channel has its interrupt input raised, and it holds software block bits for each channel. The block combines these into one registered, level-sensitive interrupt output. Offsets 4 to 7 of each window belong to the descriptor-address logic outside this block, so they are not decoded here.

Top module: `bmdma_regs`

## Requirements
- R1: Address bit 3 selects the channel and bits 1:0 select the register: 0 is command, 1 is mode, 2 is status, 3 is timing. When address bit 2 is 1, a read returns 0x00 and a write changes nothing.
- R2: `rdata_o` takes the addressed value on the clock edge where `rd_en_i` is high. It holds that value while `rd_en_i` is low.
- R3: A command write stores the whole byte for that channel. `start_o[c]` is bit 0 and `dir_o[c]` is bit 3 of channel c's command byte, and `cmd_o` carries both bytes with channel 0 in the low byte.
- R4: Both windows show the same mode register. Bit 2 is channel 0 pending, bit 3 is channel 1 pending, bit 4 blocks channel 0 and bit 5 blocks channel 1. A write changes only bits 5:4, and the other bits read as 0.
- R5: A channel's pending bit equals that channel's `chan_irq_i` as sampled on the previous clock edge.
- R6: `irq_o` is registered. One cycle after the pending and block bits reach a state, it is high if any channel is pending and not blocked.
- R7: Status byte layout:
  - Bit 0 shows `eng_active_i` and cannot be written.
  - Bits 6:5 take the written data.
  - Bits 2:1 clear where the written data has a 1 and are kept where it has a 0.
  - Bits 7, 4 and 3 read as 0.
- R8: A pulse on `eng_err_i` sets status bit 1, and a pulse on `eng_done_i` sets status bit 2. A pulse wins over a clear written in the same cycle.
- R9: Each channel has its own timing byte, which is fully writable and readable.
- R10: Reset clears every register, `rdata_o`, `irq_o`, `start_o` and `dir_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Byte write strobe |
| rd_en_i | input | 1 | Byte read strobe |
| addr_i | input | 4 | Byte address within the block |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid the cycle after the strobe |
| chan_irq_i | input | 2 | Per-channel interrupt level |
| eng_active_i | input | 2 | Per-channel engine active flag |
| eng_err_i | input | 2 | Per-channel error event pulse |
| eng_done_i | input | 2 | Per-channel interrupt event pulse |
| irq_o | output | 1 | Combined level interrupt |
| cmd_o | output | 16 | Command bytes, channel 0 in bits 7:0 |
| start_o | output | 2 | Start bit of each channel |
| dir_o | output | 2 | Direction bit of each channel |

## Verification
Some behaviours are checked by assertions on every cycle:
- pending bits track the interrupt inputs one edge later;
- the interrupt is blocked or raised from the previous cycle's pending and block state;
- block bits and command bytes stay stable when not written;
- event pulses beat same-cycle clears.

The directed scenarios show what needs the bus, each through reads at the ports:
- the address decode and the ignored window offsets;
- the status field mix;
- the separate timing bytes;
- the read-data hold.

// File: rtl/bmdma_regs_pkg.sv
package bmdma_regs_pkg;
  localparam int unsigned DW      = 8;
  localparam int unsigned WIN_LSB = 3;   // 8-byte window stride
  localparam int unsigned PEND_LSB = 2;

  typedef enum logic [1:0] {
    SEL_CMD  = 2'd0,
    SEL_MODE = 2'd1,
    SEL_STAT = 2'd2,
    SEL_TIM  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/bmdma_chan.sv
module bmdma_chan #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_we_i,
  input  logic          stat_we_i,
  input  logic          tim_we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          active_i,
  input  logic          err_i,
  input  logic          done_i,
  output logic [DW-1:0] cmd_o,
  output logic [DW-1:0] stat_o,
  output logic [DW-1:0] tim_o
);
  logic [DW-1:0] cmd_q, tim_q;
  logic          err_q, evt_q;
  logic [1:0]    rw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
      tim_q <= '0;
      err_q <= 1'b0;
      evt_q <= 1'b0;
      rw_q  <= '0;
    end else begin
      if (cmd_we_i) cmd_q <= wdata_i;
      if (tim_we_i) tim_q <= wdata_i;
      if (stat_we_i) rw_q <= wdata_i[6:5];
      // event pulse beats a same-cycle clear
      if (err_i)                        err_q <= 1'b1;
      else if (stat_we_i && wdata_i[1]) err_q <= 1'b0;
      if (done_i)                       evt_q <= 1'b1;
      else if (stat_we_i && wdata_i[2]) evt_q <= 1'b0;
    end
  end

  always_comb begin
    stat_o    = '0;
    stat_o[0] = active_i;
    stat_o[1] = err_q;
    stat_o[2] = evt_q;
    stat_o[6:5] = rw_q;
  end

  assign cmd_o = cmd_q;
  assign tim_o = tim_q;

  assert_err_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |=> stat_o[1]);
  assert_evt_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> stat_o[2]);
  assert_w1c_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_we_i && wdata_i[2] && !done_i) |=> !stat_o[2]);
  assert_cmd_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_we_i |=> $stable(cmd_o));
endmodule

// File: rtl/bmdma_mode.sv
module bmdma_mode #(
  parameter int unsigned NCH = 2,
  parameter int unsigned DW  = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] chan_irq_i,
  input  logic           mode_we_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [DW-1:0]  mode_o,
  output logic           irq_o
);
  localparam int unsigned PEND_LSB = bmdma_regs_pkg::PEND_LSB;
  localparam int unsigned BLK_LSB  = PEND_LSB + NCH;

  logic [NCH-1:0] pend_q, blk_q;
  logic           irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      blk_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= chan_irq_i;
      if (mode_we_i) blk_q <= wdata_i[BLK_LSB +: NCH];
      irq_q <= |(pend_q & ~blk_q);
    end
  end

  always_comb begin
    mode_o = '0;
    mode_o[PEND_LSB +: NCH] = pend_q;
    mode_o[BLK_LSB +: NCH]  = blk_q;
  end

  assign irq_o = irq_q;

  assert_pend_follow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> (mode_o[PEND_LSB +: NCH] == $past(chan_irq_i)));
  assert_blk_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_we_i |=> $stable(mode_o[BLK_LSB +: NCH]));
  assert_all_blocked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&blk_q) |=> !irq_o);
  assert_none_pend_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q == '0) |=> !irq_o);
  assert_ch0_raise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q[0] && !blk_q[0]) |=> irq_o);
endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
  import bmdma_regs_pkg::*;
#(
  parameter int unsigned NCH = 2,
  parameter int unsigned AW  = WIN_LSB + $clog2(NCH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [NCH-1:0]    chan_irq_i,
  input  logic [NCH-1:0]    eng_active_i,
  input  logic [NCH-1:0]    eng_err_i,
  input  logic [NCH-1:0]    eng_done_i,
  output logic              irq_o,
  output logic [NCH*DW-1:0] cmd_o,
  output logic [NCH-1:0]    start_o,
  output logic [NCH-1:0]    dir_o
);
  localparam int unsigned CH_W = AW - WIN_LSB;

  logic [CH_W-1:0] ch_idx;
  reg_sel_e        sel;
  logic            win_hit;
  logic            mode_we;
  logic [DW-1:0]   mode_w;
  logic [NCH-1:0][DW-1:0] cmd_w, stat_w, tim_w;
  logic [DW-1:0]   rd_val, rdata_q;

  assign ch_idx  = addr_i[AW-1:WIN_LSB];
  assign sel     = reg_sel_e'(addr_i[1:0]);
  assign win_hit = !addr_i[2];
  assign mode_we = wr_en_i && win_hit && (sel == SEL_MODE);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic ch_wr;
    assign ch_wr = wr_en_i && win_hit && (ch_idx == CH_W'(c));

    bmdma_chan #(.DW(DW)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cmd_we_i  (ch_wr && (sel == SEL_CMD)),
      .stat_we_i (ch_wr && (sel == SEL_STAT)),
      .tim_we_i  (ch_wr && (sel == SEL_TIM)),
      .wdata_i   (wdata_i),
      .active_i  (eng_active_i[c]),
      .err_i     (eng_err_i[c]),
      .done_i    (eng_done_i[c]),
      .cmd_o     (cmd_w[c]),
      .stat_o    (stat_w[c]),
      .tim_o     (tim_w[c])
    );

    assign start_o[c]           = cmd_w[c][0];
    assign dir_o[c]             = cmd_w[c][3];
    assign cmd_o[c*DW +: DW]    = cmd_w[c];
  end

  bmdma_mode #(.NCH(NCH), .DW(DW)) u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .chan_irq_i (chan_irq_i),
    .mode_we_i  (mode_we),
    .wdata_i    (wdata_i),
    .mode_o     (mode_w),
    .irq_o      (irq_o)
  );

  always_comb begin
    rd_val = '0;
    if (win_hit) begin
      unique case (sel)
        SEL_CMD:  rd_val = cmd_w[ch_idx];
        SEL_MODE: rd_val = mode_w;
        SEL_STAT: rd_val = stat_w[ch_idx];
        SEL_TIM:  rd_val = tim_w[ch_idx];
        default:  rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_val;
  end

  assign rdata_o = rdata_q;

  assert_rdata_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
  assert_hole_read_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i[2]) |=> (rdata_o == '0));
endmodule

// File: tb/tb_bmdma_regs.sv
`timescale 1ns/1ps
module tb_bmdma_regs;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [3:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [1:0] chan_irq_i = '0, eng_active_i = '0, eng_err_i = '0, eng_done_i = '0;
  logic       irq_o;
  logic [15:0] cmd_o;
  logic [1:0] start_o, dir_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  bmdma_regs dut (.*);

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk_i);
    rd_en_i = 1'b1; addr_i = a;
    @(negedge clk_i);
    rd_en_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic rd_check(input string req, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    check(req, {8'h0, v}, {8'h0, exp});
  endtask

  task automatic t_reset;
    check("R10 rdata", {8'h0, rdata_o}, 16'h0);
    check("R10 irq", {15'h0, irq_o}, 16'h0);
    check("R10 cmd", cmd_o, 16'h0);
    rd_check("R10 status0", 4'd2, 8'h00);
    rd_check("R10 timing1", 4'd11, 8'h00);
  endtask

  task automatic t_cmd;
    wr(4'd0, 8'h09);
    wr(4'd8, 8'h08);
    check("R3 start", {14'h0, start_o}, 16'h1);
    check("R3 dir", {14'h0, dir_o}, 16'h3);
    check("R3 cmd_o", cmd_o, 16'h0809);
    rd_check("R1 R3 cmd0", 4'd0, 8'h09);
    rd_check("R1 R3 cmd1", 4'd8, 8'h08);
  endtask

  task automatic t_timing_and_holes;
    wr(4'd3, 8'hA5);
    wr(4'd11, 8'h5A);
    rd_check("R9 tim0", 4'd3, 8'hA5);
    rd_check("R9 tim1", 4'd11, 8'h5A);
    wr(4'd4, 8'hFF);
    wr(4'd7, 8'hFF);
    wr(4'd12, 8'hFF);
    rd_check("R1 hole read", 4'd4, 8'h00);
    rd_check("R1 hole read ch1", 4'd15, 8'h00);
    rd_check("R1 hole no effect cmd0", 4'd0, 8'h09);
    rd_check("R1 hole no effect tim0", 4'd3, 8'hA5);
    rd_check("R1 hole no effect cmd1", 4'd8, 8'h08);
    check("R1 hole no effect cmd_o", cmd_o, 16'h0809);
  endtask

  task automatic t_rdata_hold;
    rd_check("R2 read", 4'd3, 8'hA5);
    wr(4'd3, 8'h3C);
    @(negedge clk_i);
    check("R2 hold", {8'h0, rdata_o}, 16'h00A5);
    rd_check("R2 new", 4'd3, 8'h3C);
  endtask

  task automatic t_mode;
    wr(4'd1, 8'hFF);
    rd_check("R4 only 5:4", 4'd1, 8'h30);
    @(negedge clk_i); chan_irq_i = 2'b01;
    @(negedge clk_i); @(negedge clk_i);
    check("R6 blocked ch0", {15'h0, irq_o}, 16'h0);
    rd_check("R4 R5 shared view", 4'd9, 8'h34);
    wr(4'd9, 8'h20);
    check("R6 one cycle later", {15'h0, irq_o}, 16'h0);
    @(negedge clk_i);
    check("R6 unblocked ch0", {15'h0, irq_o}, 16'h1);
    rd_check("R4 after write", 4'd1, 8'h24);
    chan_irq_i = 2'b10;
    @(negedge clk_i); @(negedge clk_i);
    check("R6 ch1 blocked", {15'h0, irq_o}, 16'h0);
    rd_check("R5 pend ch1", 4'd1, 8'h28);
    wr(4'd1, 8'h00);
    @(negedge clk_i);
    check("R6 ch1 unblocked", {15'h0, irq_o}, 16'h1);
    chan_irq_i = 2'b00;
    @(negedge clk_i); @(negedge clk_i);
    check("R5 R6 dropped", {15'h0, irq_o}, 16'h0);
  endtask

  task automatic t_status;
    eng_active_i = 2'b01;
    rd_check("R7 active", 4'd2, 8'h01);
    rd_check("R7 ch1 separate", 4'd10, 8'h00);
    wr(4'd2, 8'hFF);
    rd_check("R7 rw bits", 4'd2, 8'h61);
    @(negedge clk_i); eng_done_i = 2'b01; eng_err_i = 2'b01;
    @(negedge clk_i); eng_done_i = '0; eng_err_i = '0;
    rd_check("R8 events set", 4'd2, 8'h67);
    rd_check("R8 ch1 untouched", 4'd10, 8'h00);
    wr(4'd2, 8'h64);
    rd_check("R7 w1c bit2", 4'd2, 8'h63);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = 4'd2; wdata_i = 8'h62; eng_err_i = 2'b01;
    @(negedge clk_i);
    wr_en_i = 1'b0; eng_err_i = '0;
    rd_check("R8 pulse beats clear", 4'd2, 8'h63);
    wr(4'd2, 8'h02);
    rd_check("R7 clear bit1 and rw", 4'd2, 8'h01);
    eng_active_i = 2'b00;
    rd_check("R7 bit0 tracks input", 4'd2, 8'h00);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_cmd();
    t_timing_and_holes();
    t_rdata_hold();
    t_mode();
    t_status();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule